// File: doc/BRIEF.md
# Synchronous slave FIFO burst read sequencer

This block is the master side of a synchronous slave FIFO port. A request gives a FIFO address and a word count. The block then drives the port through a fixed sequence. It drives the address and asserts the active-low chip select, and holds both for a configurable number of address-setup cycles. It then enables the slave's output drivers, so that the word the slave has prefetched is on the bus. One cycle later it pulls the read strobe low. The output enable and the strobe stay low for the whole burst, and one word is consumed at every rising clock edge.

Each word is sampled at a rising edge where the strobe is low and the FIFO is not empty. It is presented on `out_data` with a one-cycle `out_valid` pulse in the following cycle. If the empty flag is seen at a read edge, the strobe is raised before the next edge and the transfer ends short. The port is then released in a fixed order: strobe, then output enable, then chip select, one cycle apart. A one-cycle done pulse reports the number of words taken and whether the transfer ended short.

Top module: `sfifo_burst_reader`

## Requirements
- R1: During reset and after it, `busy`, `out_valid`, `done` and `done_short` are 0, and `fifo_cs_n`, `fifo_oe_n` and `fifo_rd_n` are 1.
- R2: `req_valid` is accepted only at an edge where `busy` is 0. A request raised while `busy` is 1 is ignored: it does not change the address or the timing of the running transfer, and it does not start a second transfer.
- R3: From the first cycle after acceptance, `fifo_cs_n` is 0 and `fifo_addr` carries the accepted address. The address stays constant for as long as `fifo_cs_n` is 0.
- R4: `fifo_rd_n` first goes low in cycle SETUP_CYC+1 after the accepting edge, so chip select and address lead the first read edge by SETUP_CYC cycles (SETUP_CYC ≥ 2).
- R5: `fifo_oe_n` goes low in cycle SETUP_CYC, exactly one cycle before the strobe. Both stay low without a gap through every read cycle of the burst.
- R6: A requested count n from 1 to MAX_WORDS gives n read edges when the FIFO holds at least n words. A count of 0 is treated as 1. A count above MAX_WORDS is treated as MAX_WORDS.
- R7: At every rising edge where `fifo_rd_n` is 0 and `fifo_empty` is 0, the word on `fifo_data` is captured. It appears on `out_data` with `out_valid` 1 in the next cycle only.
- R8: At a read edge where `fifo_empty` is 1, nothing is captured, `fifo_rd_n` is 1 in the next cycle, and the transfer ends with `done_short` set.
- R9: After the last read edge, `fifo_rd_n` rises in the next cycle, `fifo_oe_n` one cycle later and `fifo_cs_n` one cycle after that. `done` is 1 for exactly that cycle, with `done_count` equal to the number of words captured. `busy` falls in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the slave FIFO port |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a transfer (taken when idle) |
| req_addr | input | ADDR_W | FIFO select address for the transfer |
| req_count | input | CNT_W | Words to read (0 means 1; clamped to MAX_WORDS) |
| busy | output | 1 | Transfer in progress |
| fifo_addr | output | ADDR_W | FIFO address to the slave |
| fifo_cs_n | output | 1 | Active-low chip select |
| fifo_oe_n | output | 1 | Active-low output enable of the slave's data drivers |
| fifo_rd_n | output | 1 | Active-low read strobe |
| fifo_data | input | DATA_W | Data bus from the slave |
| fifo_empty | input | 1 | Slave empty flag, active high |
| out_valid | output | 1 | One-cycle strobe for a captured word |
| out_data | output | DATA_W | Captured word |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_short | output | 1 | With `done`: transfer stopped on empty |
| done_count | output | CNT_W | With `done`: words captured |

## Verification
All timing is counted from the accepting edge. With S setup cycles, effective count n and a words present in the FIFO, the number of read edges is R = n, or a+1 when a < n. The chip select is low from cycle 1, the output enable from cycle S, the strobe from cycle S+1 to S+R, and the done pulse falls in cycle S+R+3. A word captured at the edge that ends cycle c is due on the output in cycle c+1. The bench sets the inputs on falling edges and compares every port with these windows at each falling edge, one cycle past the done pulse. It sweeps the count past both ends of its range and the fill level around the count, and it raises competing requests during half the transfers.

// File: rtl/sfifo_burst_reader_pkg.sv
package sfifo_burst_reader_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SETUP   = 3'd1,
      ST_LEAD    = 3'd2,
      ST_READ    = 3'd3,
      ST_TAIL_OE = 3'd4,
      ST_TAIL_CS = 3'd5,
      ST_DONE    = 3'd6
   } rdseq_state_e;

endpackage

// File: rtl/sfbr_setup_timer.sv
// Counts the address-setup cycles spent in the setup state.
// Used only when more than one bare setup cycle is configured.
module sfbr_setup_timer #(
   parameter int SETUP_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic expired
);
   localparam int CW = (SETUP_CYC > 2) ? $clog2(SETUP_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(SETUP_CYC - 2);

   logic [CW-1:0] ticks;

   always_ff @(posedge clk) begin
      if (!rst_n || !active) ticks <= '0;
      else                   ticks <= ticks + CW'(1);
   end

   assign expired = active && (ticks == LAST);
endmodule

// File: rtl/sfbr_word_ctr.sv
// Holds the effective target and counts the words taken.
module sfbr_word_ctr #(
   parameter int MAX_WORDS = 256,
   parameter int CNT_W     = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] req_count,
   input  logic             take,
   output logic             last,
   output logic [CNT_W-1:0] taken
);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_WORDS);

   logic [CNT_W-1:0] target;
   logic [CNT_W-1:0] eff_count;

   always_comb begin
      if (req_count == '0)     eff_count = CNT_W'(1);
      else if (req_count > CAP) eff_count = CAP;
      else                      eff_count = req_count;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         target <= CNT_W'(1);
         taken  <= '0;
      end else if (load) begin
         target <= eff_count;
         taken  <= '0;
      end else if (take) begin
         taken  <= taken + CNT_W'(1);
      end
   end

   assign last = (taken + CNT_W'(1)) == target;
endmodule

// File: rtl/sfbr_capture.sv
// Registers a bus word and its one-cycle valid strobe.
module sfbr_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   output logic              valid,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else begin
         valid <= take;
         if (take) dout <= din;
      end
   end
endmodule

// File: rtl/sfifo_burst_reader.sv
module sfifo_burst_reader
   import sfifo_burst_reader_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 2,
   parameter int MAX_WORDS = 256,
   parameter int SETUP_CYC = 2,
   localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CNT_W-1:0]  req_count,
   output logic              busy,
   output logic [ADDR_W-1:0] fifo_addr,
   output logic              fifo_cs_n,
   output logic              fifo_oe_n,
   output logic              fifo_rd_n,
   input  logic [DATA_W-1:0] fifo_data,
   input  logic              fifo_empty,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              done,
   output logic              done_short,
   output logic [CNT_W-1:0]  done_count
);
   if (SETUP_CYC < 2) begin : g_bad_setup
      $error("SETUP_CYC must be at least 2");
   end
   if (MAX_WORDS < 1) begin : g_bad_max
      $error("MAX_WORDS must be at least 1");
   end
   if (DATA_W < 1 || ADDR_W < 1) begin : g_bad_width
      $error("DATA_W and ADDR_W must be positive");
   end

   rdseq_state_e      state, state_nx;
   logic [ADDR_W-1:0] addr_q;
   logic              short_q;
   logic              accept;
   logic              setup_done;
   logic              take;
   logic              last;
   logic [CNT_W-1:0]  taken;

   assign accept = (state == ST_IDLE) && req_valid;
   assign take   = (state == ST_READ) && !fifo_empty;

   // variant: a single bare setup cycle needs no timer
   if (SETUP_CYC == 2) begin : g_setup_min
      assign setup_done = 1'b1;
   end else begin : g_setup_timer
      sfbr_setup_timer #(.SETUP_CYC(SETUP_CYC)) u_timer (
         .clk    (clk),
         .rst_n  (rst_n),
         .active (state == ST_SETUP),
         .expired(setup_done)
      );
   end

   sfbr_word_ctr #(.MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .req_count(req_count),
      .take     (take),
      .last     (last),
      .taken    (taken)
   );

   sfbr_capture #(.DATA_W(DATA_W)) u_cap (
      .clk  (clk),
      .rst_n(rst_n),
      .take (take),
      .din  (fifo_data),
      .valid(out_valid),
      .dout (out_data)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:    if (req_valid) state_nx = ST_SETUP;
         ST_SETUP:   if (setup_done) state_nx = ST_LEAD;
         ST_LEAD:    state_nx = ST_READ;
         ST_READ:    if (fifo_empty || last) state_nx = ST_TAIL_OE;
         ST_TAIL_OE: state_nx = ST_TAIL_CS;
         ST_TAIL_CS: state_nx = ST_DONE;
         ST_DONE:    state_nx = ST_IDLE;
         default:    state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         addr_q  <= '0;
         short_q <= 1'b0;
      end else begin
         state <= state_nx;
         if (accept) begin
            addr_q  <= req_addr;
            short_q <= 1'b0;
         end else if (state == ST_READ && fifo_empty) begin
            short_q <= 1'b1;
         end
      end
   end

   assign busy       = (state != ST_IDLE);
   assign fifo_addr  = addr_q;
   assign fifo_cs_n  = (state == ST_IDLE) || (state == ST_DONE);
   assign fifo_oe_n  = !((state == ST_LEAD) || (state == ST_READ) || (state == ST_TAIL_OE));
   assign fifo_rd_n  = (state != ST_READ);
   assign done       = (state == ST_DONE);
   assign done_short = done && short_q;
   assign done_count = done ? taken : '0;
endmodule

// File: rtl/sfifo_burst_reader_chk.sv
module sfifo_burst_reader_chk #(
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic [ADDR_W-1:0] fifo_addr,
   input logic              fifo_cs_n,
   input logic              fifo_oe_n,
   input logic              fifo_rd_n,
   input logic              fifo_empty,
   input logic              out_valid,
   input logic              done,
   input logic              done_short
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (fifo_cs_n && fifo_oe_n && fifo_rd_n && !out_valid));

   p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_cs_n && $past(fifo_cs_n) == 1'b0) |-> $stable(fifo_addr));

   p_cs_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fifo_rd_n) |-> ($past(fifo_cs_n, 2) == 1'b0));

   p_rd_needs_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_rd_n |-> !fifo_cs_n);

   p_oe_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fifo_rd_n) |-> ($past(fifo_oe_n) == 1'b0));

   p_oe_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_rd_n |-> !fifo_oe_n);

   p_valid_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($past(fifo_rd_n) == 1'b0));

   p_empty_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_rd_n && fifo_empty) |=> (fifo_rd_n && !out_valid));

   p_short_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_short |-> done);

   p_oe_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_oe_n) |-> (fifo_rd_n && $past(fifo_rd_n)));

   p_cs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fifo_cs_n) |-> (fifo_oe_n && $past(fifo_oe_n) && done));

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
endmodule

bind sfifo_burst_reader sfifo_burst_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .fifo_addr (fifo_addr),
   .fifo_cs_n (fifo_cs_n),
   .fifo_oe_n (fifo_oe_n),
   .fifo_rd_n (fifo_rd_n),
   .fifo_empty(fifo_empty),
   .out_valid (out_valid),
   .done      (done),
   .done_short(done_short)
);

// File: tb/sfifo_burst_reader_test.sv
`timescale 1ns/1ps
module sfifo_burst_reader_test;
   localparam int DW   = 16;
   localparam int AW   = 3;
   localparam int MAXW = 16;
   localparam int S    = 3;
   localparam int CW   = $clog2(MAXW + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [CW-1:0] req_count = '0;
   logic          busy, fifo_cs_n, fifo_oe_n, fifo_rd_n;
   logic [AW-1:0] fifo_addr;
   logic [DW-1:0] fifo_data;
   logic          fifo_empty;
   logic          out_valid, done, done_short;
   logic [DW-1:0] out_data;
   logic [CW-1:0] done_count;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // slave FIFO model
   int  avail = 0;
   int  rptr  = 0;
   bit  load_req = 1'b0;
   int  load_val = 0;

   function automatic logic [DW-1:0] word_at(input int i);
      return DW'(i * 37 + 5) ^ 16'h5A00;
   endfunction

   assign fifo_empty = (avail == 0);
   assign fifo_data  = !fifo_oe_n ? word_at(rptr) : 16'hFFFF;

   always @(posedge clk) begin
      if (load_req) avail <= load_val;
      else if (!fifo_cs_n && !fifo_rd_n && avail > 0) begin
         avail <= avail - 1;
         rptr  <= rptr + 1;
      end
   end

   always #4 clk = ~clk;

   sfifo_burst_reader #(.DATA_W(DW), .ADDR_W(AW), .MAX_WORDS(MAXW), .SETUP_CYC(S)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_count(req_count), .busy(busy), .fifo_addr(fifo_addr),
      .fifo_cs_n(fifo_cs_n), .fifo_oe_n(fifo_oe_n), .fifo_rd_n(fifo_rd_n),
      .fifo_data(fifo_data), .fifo_empty(fifo_empty), .out_valid(out_valid),
      .out_data(out_data), .done(done), .done_short(done_short), .done_count(done_count)
   );

   task automatic chk(input string tag, input int k, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, k, act, exp);
      end
   endtask

   // one transfer: n requested, a words in the FIFO, noisy = extra requests while busy
   task automatic run_xfer(input int n, input int a, input logic [AW-1:0] adr, input bit noisy);
      int ne, words, rcnt, tlen, base;
      bit sh;
      ne    = (n == 0) ? 1 : ((n > MAXW) ? MAXW : n);
      sh    = (a < ne);
      words = sh ? a : ne;
      rcnt  = sh ? a + 1 : ne;
      tlen  = S + rcnt + 3;
      base  = rptr;
      @(negedge clk);
      load_req = 1'b1; load_val = a;
      @(negedge clk);
      load_req  = 1'b0;
      req_valid = 1'b1; req_addr = adr; req_count = CW'(n);
      for (int k = 1; k <= tlen + 2; k++) begin
         @(negedge clk);
         req_valid = noisy && (k < tlen);
         req_addr  = ~adr;
         req_count = CW'(MAXW);
         // R2/R3/R4/R5/R9: control pins against their cycle windows
         chk("R9 busy", k, 64'(busy), 64'(k <= tlen));
         chk("R3 cs_n", k, 64'(fifo_cs_n), 64'(!(k >= 1 && k <= tlen - 1)));
         chk("R5 oe_n", k, 64'(fifo_oe_n), 64'(!(k >= S && k <= S + rcnt + 1)));
         chk("R4 R6 R8 rd_n", k, 64'(fifo_rd_n), 64'(!(k >= S + 1 && k <= S + rcnt)));
         chk("R9 done", k, 64'(done), 64'(k == tlen));
         chk("R7 out_valid", k, 64'(out_valid), 64'(k >= S + 2 && k <= S + words + 1));
         if (k >= S + 2 && k <= S + words + 1)
            chk("R7 out_data", k, 64'(out_data), 64'(word_at(base + k - S - 2)));
         if (k <= tlen - 1)
            chk("R2 R3 fifo_addr", k, 64'(fifo_addr), 64'(adr));
         if (k == tlen) begin
            chk("R8 done_short", k, 64'(done_short), 64'(sh));
            chk("R9 done_count", k, 64'(done_count), 64'(words));
         end
      end
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1 busy", 0, 64'(busy), 64'd0);
      chk("R1 strobes", 0, 64'({fifo_cs_n, fifo_oe_n, fifo_rd_n}), 64'b111);
      chk("R1 out", 0, 64'({out_valid, done, done_short}), 64'b000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", 0, 64'({busy, fifo_cs_n, fifo_oe_n, fifo_rd_n, done}), 64'b01110);
      // R6: counts over and past the full range, fill levels around the count
      for (int n = 0; n <= 20; n++) begin
         int ne;
         ne = (n == 0) ? 1 : ((n > MAXW) ? MAXW : n);
         run_xfer(n, ne + 3, AW'(n), n[0]);
         run_xfer(n, ne, AW'(n + 1), !n[0]);
         if (ne >= 1) run_xfer(n, ne - 1, AW'(n + 2), n[0]);
         run_xfer(n, 0, AW'(n + 3), 1'b1);
      end
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule